// File: doc/BRIEF.md
# Ordered Store Queue with Write-Back Pointer

This block holds stores between dispatch and memory write-back. It is a circular buffer with one more slot than its usable capacity. The spare slot keeps the tail from ever landing on the head of a full ring. A store is allocated at the tail when it is dispatched. Its address, size and data arrive later from the address stage. A commit sweep marks every store up to a given sequence number as committed and eligible for write-back.

A separate write-back pointer walks from the head toward the tail. It presents one eligible store at a time to the memory port over a request/accept handshake. A refused request blocks the port until a retry pulse arrives. Write-back completions return in order. Each completion frees the head slot. A squash drops every uncommitted store younger than a given sequence number by pulling the tail back, with wraparound.

Top module: `sq_store_queue`

## Requirements
- R1: An allocation that is accepted writes the store into the slot shown on `alloc_idx` (the tail). One cycle later `occupancy` has risen by one and `alloc_idx` has moved forward by one, wrapping from DEPTH back to 0 over DEPTH+1 slots.
- R2: `full` is high when `occupancy` equals DEPTH, which is the slot count minus one. An allocation while full is ignored: `occupancy` and `alloc_idx` stay unchanged.
- R3: A fill at a live slot index stores that slot's address, size and data. These are the values presented on `wb_req_addr`, `wb_req_size` and `wb_req_data` when that store is written back. A newly allocated store has size zero.
- R4: A commit marks every live, uncommitted store whose sequence number is at most `commit_seq`. One cycle later `wb_pending` has risen by the number of stores newly marked. A store that is already committed is not counted again.
- R5: `wb_will` is high exactly when the slot at the write-back pointer is live, committed and not completed, and the port is not blocked.
- R6: A request that is accepted (`wb_will` and `wb_req_ready` both high) moves the write-back pointer on by one and lowers `wb_pending` by one. A refused request (`wb_will` high, `wb_req_ready` low) blocks the port. `wb_will` then stays low until the cycle after a `wb_retry` pulse.
- R7: `wb_done` completes and frees the head store. One cycle later `occupancy` is one lower and `head_seq` shows the next store.
- R8: A squash removes every live, uncommitted store with a sequence number above `squash_seq`. The tail moves back by the number of stores removed, with wraparound. An allocation in the same cycle is ignored.
- R9: `head_seq` is zero whenever the queue is empty.
- R10: `has_wb` is high exactly when `wb_pending` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated store |
| alloc_idx | output | IDX_W | Current tail slot; the slot the next allocation takes |
| fill_valid | input | 1 | Write address, size and data into a slot |
| fill_idx | input | IDX_W | Slot to fill |
| fill_addr | input | ADDR_W | Store address |
| fill_size | input | SIZE_W | Store size in bytes |
| fill_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit sweep request |
| commit_seq | input | SEQ_W | Youngest sequence number to commit |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Youngest sequence number to keep |
| wb_will | output | 1 | Write-back request valid this cycle |
| wb_req_addr | output | ADDR_W | Address of the store being written back |
| wb_req_size | output | SIZE_W | Size of the store being written back |
| wb_req_data | output | DATA_W | Data of the store being written back |
| wb_req_ready | input | 1 | Memory port accepts the request |
| wb_retry | input | 1 | Memory port can take requests again |
| wb_done | input | 1 | Oldest outstanding write-back has completed |
| occupancy | output | CNT_W | Number of live stores |
| full | output | 1 | Queue holds DEPTH stores |
| wb_pending | output | CNT_W | Committed stores not yet accepted by memory |
| has_wb | output | 1 | At least one store is pending write-back |
| head_seq | output | SEQ_W | Sequence number at the head, zero if empty |

## Verification
Every state change here is one register deep. An allocation, fill, commit, squash, acceptance, refusal, retry or completion sampled at one clock edge shows up on the outputs right after that edge. `wb_will` and the request fields follow combinationally from the stored state and the blocked flag. The bench drives a set of inputs and advances its behavioural model by the same step. It then waits for the rising edge and compares every output with the model at the following falling edge, so each result is checked in the cycle it is due. Directed checks on the blocking, squash and full cases are read at that same point.

// File: rtl/sq_pkg.sv
package sq_pkg;

   // per-slot status bits
   typedef struct packed {
      logic can_wb;
      logic committed;
      logic completed;
   } sq_flags_t;

   // advance a ring pointer by amt over n slots
   function automatic int unsigned ring_fwd(int unsigned p, int unsigned amt, int unsigned n);
      return (p + amt) % n;
   endfunction

   // retreat a ring pointer by amt over n slots
   function automatic int unsigned ring_back(int unsigned p, int unsigned amt, int unsigned n);
      return (p + n - (amt % n)) % n;
   endfunction

endpackage

// File: rtl/sq_slot_bank.sv
module sq_slot_bank
   import sq_pkg::*;
#(
   parameter int SLOTS  = 5,
   parameter int IDX_W  = 3,
   parameter int SEQ_W  = 16,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int SIZE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [IDX_W-1:0]  alloc_at,
   input  logic [SEQ_W-1:0]  alloc_seq,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_at,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [SIZE_W-1:0] fill_size,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              commit_en,
   input  logic [SEQ_W-1:0]  commit_seq,
   input  logic              squash_en,
   input  logic [SEQ_W-1:0]  squash_seq,
   input  logic              free_en,
   input  logic [IDX_W-1:0]  free_at,
   input  logic [IDX_W-1:0]  rd_at,
   input  logic [IDX_W-1:0]  hd_at,
   output logic [SLOTS-1:0]  newc_vec,
   output logic [SLOTS-1:0]  kill_vec,
   output logic              rd_live,
   output sq_flags_t         rd_flags,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [SIZE_W-1:0] rd_size,
   output logic [DATA_W-1:0] rd_data,
   output logic              hd_live,
   output logic [SEQ_W-1:0]  hd_seq
);

   logic [SLOTS-1:0]  live_w;
   logic [SEQ_W-1:0]  seq_w  [SLOTS];
   logic [ADDR_W-1:0] addr_w [SLOTS];
   logic [SIZE_W-1:0] size_w [SLOTS];
   logic [DATA_W-1:0] data_w [SLOTS];
   sq_flags_t         flag_w [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic              v_r;
      logic [SEQ_W-1:0]  s_r;
      logic [ADDR_W-1:0] a_r;
      logic [SIZE_W-1:0] z_r;
      logic [DATA_W-1:0] d_r;
      sq_flags_t         f_r;
      logic              hit_alloc, hit_free, hit_fill, newc, kill;

      assign hit_alloc = alloc_en && (alloc_at == IDX_W'(g));
      assign hit_free  = free_en  && (free_at  == IDX_W'(g));
      assign hit_fill  = fill_en  && (fill_at  == IDX_W'(g)) && v_r;
      assign newc      = commit_en && v_r && !f_r.committed && (s_r <= commit_seq);
      assign kill      = squash_en && v_r && !f_r.committed && (s_r > squash_seq);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_r <= 1'b0;
            s_r <= '0;
            a_r <= '0;
            z_r <= '0;
            d_r <= '0;
            f_r <= '0;
         end else if (hit_alloc) begin
            v_r <= 1'b1;
            s_r <= alloc_seq;
            a_r <= '0;
            z_r <= '0;
            d_r <= '0;
            f_r <= '0;
         end else if (hit_free) begin
            v_r          <= 1'b0;
            f_r.completed <= 1'b1;
         end else if (kill) begin
            v_r <= 1'b0;
         end else begin
            if (hit_fill) begin
               a_r <= fill_addr;
               z_r <= fill_size;
               d_r <= fill_data;
            end
            if (newc) begin
               f_r.committed <= 1'b1;
               f_r.can_wb    <= 1'b1;
            end
         end
      end

      assign newc_vec[g] = newc;
      assign kill_vec[g] = kill;
      assign live_w[g]   = v_r;
      assign seq_w[g]    = s_r;
      assign addr_w[g]   = a_r;
      assign size_w[g]   = z_r;
      assign data_w[g]   = d_r;
      assign flag_w[g]   = f_r;
   end

   assign rd_live  = live_w[rd_at];
   assign rd_flags = flag_w[rd_at];
   assign rd_addr  = addr_w[rd_at];
   assign rd_size  = size_w[rd_at];
   assign rd_data  = data_w[rd_at];
   assign hd_live  = live_w[hd_at];
   assign hd_seq   = seq_w[hd_at];

   // R1: the tail slot handed out is never occupied
   p_alloc_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !live_w[alloc_at]);

   // R3: a slot that is allocated starts with size zero
   p_alloc_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |=> (size_w[$past(alloc_at)] == '0));

endmodule

// File: rtl/sq_wb_port.sv
module sq_wb_port
   import sq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      slot_live,
   input  sq_flags_t slot_flags,
   input  logic      mem_ready,
   input  logic      mem_retry,
   output logic      req,
   output logic      accept
);

   logic blocked_r;

   assign req    = slot_live && slot_flags.can_wb && !slot_flags.completed && !blocked_r;
   assign accept = req && mem_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)                  blocked_r <= 1'b0;
      else if (req && !mem_ready)  blocked_r <= 1'b1;
      else if (mem_retry)          blocked_r <= 1'b0;
   end

   // R6: a refused request silences the port in the following cycle
   p_refuse_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !mem_ready) |=> !req);

   // R6: while blocked and no retry comes, the port stays silent
   p_block_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && blocked_r && !mem_retry) |=> !req);

endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue
   import sq_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int SEQ_W  = 16,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int SIZE_W = 4,
   localparam int SLOTS = DEPTH + 1,
   localparam int IDX_W = $clog2(SLOTS),
   localparam int CNT_W = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [SEQ_W-1:0]  alloc_seq,
   output logic [IDX_W-1:0]  alloc_idx,
   input  logic              fill_valid,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [SIZE_W-1:0] fill_size,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              commit_valid,
   input  logic [SEQ_W-1:0]  commit_seq,
   input  logic              squash_valid,
   input  logic [SEQ_W-1:0]  squash_seq,
   output logic              wb_will,
   output logic [ADDR_W-1:0] wb_req_addr,
   output logic [SIZE_W-1:0] wb_req_size,
   output logic [DATA_W-1:0] wb_req_data,
   input  logic              wb_req_ready,
   input  logic              wb_retry,
   input  logic              wb_done,
   output logic [CNT_W-1:0]  occupancy,
   output logic              full,
   output logic [CNT_W-1:0]  wb_pending,
   output logic              has_wb,
   output logic [SEQ_W-1:0]  head_seq
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sq_store_queue: DEPTH must be at least 2");
   end
   if (SEQ_W < 2 || ADDR_W < 1 || DATA_W < 8 || SIZE_W < 1) begin : g_bad_width
      $error("sq_store_queue: field widths out of range");
   end

   logic [IDX_W-1:0] head_r, tail_r, wbp_r;
   logic [CNT_W-1:0] count_r, pend_r;
   logic [SLOTS-1:0] newc_vec, kill_vec;
   logic             rd_live, hd_live, accept, alloc_ok;
   sq_flags_t        rd_flags;
   logic [SEQ_W-1:0] hd_seq_raw;
   logic [CNT_W-1:0] n_new, n_kill;

   assign full     = (count_r >= CNT_W'(SLOTS - 1));
   assign alloc_ok = alloc_valid && !squash_valid && !full;
   assign n_new    = CNT_W'($countones(newc_vec));
   assign n_kill   = CNT_W'($countones(kill_vec));

   sq_slot_bank #(
      .SLOTS (SLOTS), .IDX_W (IDX_W), .SEQ_W (SEQ_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
   ) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (alloc_ok),
      .alloc_at  (tail_r),
      .alloc_seq (alloc_seq),
      .fill_en   (fill_valid),
      .fill_at   (fill_idx),
      .fill_addr (fill_addr),
      .fill_size (fill_size),
      .fill_data (fill_data),
      .commit_en (commit_valid),
      .commit_seq(commit_seq),
      .squash_en (squash_valid),
      .squash_seq(squash_seq),
      .free_en   (wb_done),
      .free_at   (head_r),
      .rd_at     (wbp_r),
      .hd_at     (head_r),
      .newc_vec  (newc_vec),
      .kill_vec  (kill_vec),
      .rd_live   (rd_live),
      .rd_flags  (rd_flags),
      .rd_addr   (wb_req_addr),
      .rd_size   (wb_req_size),
      .rd_data   (wb_req_data),
      .hd_live   (hd_live),
      .hd_seq    (hd_seq_raw)
   );

   sq_wb_port i_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_live (rd_live),
      .slot_flags(rd_flags),
      .mem_ready (wb_req_ready),
      .mem_retry (wb_retry),
      .req       (wb_will),
      .accept    (accept)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_r  <= '0;
         tail_r  <= '0;
         wbp_r   <= '0;
         count_r <= '0;
         pend_r  <= '0;
      end else begin
         if (squash_valid)
            tail_r <= IDX_W'(ring_back(int'(tail_r), int'(n_kill), SLOTS));
         else if (alloc_ok)
            tail_r <= IDX_W'(ring_fwd(int'(tail_r), 1, SLOTS));
         if (wb_done)
            head_r <= IDX_W'(ring_fwd(int'(head_r), 1, SLOTS));
         if (accept)
            wbp_r <= IDX_W'(ring_fwd(int'(wbp_r), 1, SLOTS));
         count_r <= count_r + CNT_W'(alloc_ok) - CNT_W'(wb_done) - n_kill;
         pend_r  <= pend_r + n_new - CNT_W'(accept);
      end
   end

   assign alloc_idx  = tail_r;
   assign occupancy  = count_r;
   assign wb_pending = pend_r;
   assign has_wb     = (pend_r != '0);
   assign head_seq   = hd_live ? hd_seq_raw : '0;

   // R2: never more stores than usable slots
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= CNT_W'(DEPTH));

   // R2: allocation while full leaves the tail where it was
   p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (full && alloc_valid && !squash_valid) |=> (alloc_idx == $past(alloc_idx)));

   // R9: empty queue reports a zero head sequence
   p_empty_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy == '0) |-> (head_seq == '0));

   // R4: pending write-backs never exceed the stores held
   p_pend_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_pending <= occupancy);

   // R7: a completion only arrives while a store is held
   p_done_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_done |-> (occupancy != '0));

endmodule

// File: tb/test_sq_store_queue.sv
module test_sq_store_queue;

   localparam int DEPTH = 4;
   localparam int SLOTS = DEPTH + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_v = 0, f_v = 0, c_v = 0, s_v = 0, m_ready = 1, m_retry = 0, d_v = 0;
   logic [15:0] a_seq = 0, c_seq = 0, s_seq = 0;
   logic [2:0]  f_idx = 0;
   logic [31:0] f_addr = 0;
   logic [3:0]  f_size = 0;
   logic [63:0] f_data = 0;

   logic [2:0]  alloc_idx;
   logic        wb_will, full, has_wb;
   logic [31:0] wb_req_addr;
   logic [3:0]  wb_req_size;
   logic [63:0] wb_req_data;
   logic [2:0]  occupancy, wb_pending;
   logic [15:0] head_seq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sq_store_queue #(.DEPTH(DEPTH)) i_sq_store_queue (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(a_v), .alloc_seq(a_seq), .alloc_idx(alloc_idx),
      .fill_valid(f_v), .fill_idx(f_idx), .fill_addr(f_addr),
      .fill_size(f_size), .fill_data(f_data),
      .commit_valid(c_v), .commit_seq(c_seq),
      .squash_valid(s_v), .squash_seq(s_seq),
      .wb_will(wb_will), .wb_req_addr(wb_req_addr), .wb_req_size(wb_req_size),
      .wb_req_data(wb_req_data), .wb_req_ready(m_ready), .wb_retry(m_retry),
      .wb_done(d_v), .occupancy(occupancy), .full(full),
      .wb_pending(wb_pending), .has_wb(has_wb), .head_seq(head_seq)
   );

   // behavioural model
   typedef struct {
      int     seq;
      longint addr;
      int     size;
      longint data;
      bit     com;
   } m_ent_t;

   m_ent_t q[$];
   int hd = 0, wbn = 0, pend = 0;
   bit blk = 0;

   function automatic int slot_of(int i);
      return (hd + i) % SLOTS;
   endfunction

   function automatic bit m_will();
      return !blk && (wbn < q.size()) && q[wbn].com;
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit w;
      w = m_will();
      chk("R1 occupancy", occupancy, q.size());
      chk("R1 alloc_idx", alloc_idx, (hd + q.size()) % SLOTS);
      chk("R2 full", full, q.size() == DEPTH);
      chk("R9 head_seq", head_seq, q.size() > 0 ? q[0].seq : 0);
      chk("R5 wb_will", wb_will, w);
      chk("R4 wb_pending", wb_pending, pend);
      chk("R10 has_wb", has_wb, pend != 0);
      if (w && wb_will) begin
         chk("R3 wb_req_addr", wb_req_addr, q[wbn].addr);
         chk("R3 wb_req_size", wb_req_size, q[wbn].size);
         chk("R3 wb_req_data", wb_req_data, q[wbn].data);
      end
   endtask

   task automatic model_update();
      bit w, acc, refu;
      int cnt0;
      m_ent_t e;
      w    = m_will();
      acc  = w && m_ready;
      refu = w && !m_ready;
      cnt0 = q.size();
      if (f_v)
         for (int i = 0; i < q.size(); i++)
            if (slot_of(i) == int'(f_idx)) begin
               q[i].addr = f_addr; q[i].size = f_size; q[i].data = f_data;
            end
      if (c_v)
         for (int i = 0; i < q.size(); i++)
            if (!q[i].com && q[i].seq <= int'(c_seq)) begin
               q[i].com = 1; pend++;
            end
      if (acc) begin wbn++; pend--; end
      if (refu) blk = 1;
      else if (m_retry) blk = 0;
      if (s_v)
         while (q.size() > 0 && q[q.size()-1].seq > int'(s_seq) && !q[q.size()-1].com)
            void'(q.pop_back());
      if (d_v) begin
         void'(q.pop_front());
         hd = (hd + 1) % SLOTS;
         wbn--;
      end
      if (a_v && !s_v && cnt0 < DEPTH) begin
         e.seq = a_seq; e.addr = 0; e.size = 0; e.data = 0; e.com = 0;
         q.push_back(e);
      end
   endtask

   task automatic step();
      model_update();
      @(posedge clk);
      @(negedge clk);
      a_v = 0; f_v = 0; c_v = 0; s_v = 0; d_v = 0; m_retry = 0; m_ready = 1;
      compare();
   endtask

   task automatic fill_at(int i);
      f_v    = 1;
      f_idx  = 3'(slot_of(i));
      f_addr = 32'h1000 + 32'(q[i].seq) * 8;
      f_size = 4'(1 << (q[i].seq % 4));
      f_data = 64'h5A00_0000_0000_0000 + 64'(q[i].seq) * 64'h0101;
   endtask

   initial begin
      #(5 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int nseq;
      repeat (3) @(negedge clk);
      rst_n = 1;
      compare();
      chk("R9 reset head_seq", head_seq, 0);
      chk("R1 reset occupancy", occupancy, 0);

      // fill the queue: seq 10..13
      for (int k = 0; k < DEPTH; k++) begin
         a_v = 1; a_seq = 16'(10 + k);
         step();
      end
      chk("R2 full at depth", full, 1);
      chk("R1 tail wrapped index", alloc_idx, 4);
      a_v = 1; a_seq = 14;
      step();
      chk("R2 alloc ignored occupancy", occupancy, 4);
      chk("R2 alloc ignored idx", alloc_idx, 4);

      for (int k = 0; k < DEPTH; k++) begin
         fill_at(k);
         step();
      end

      // commit 10 and 11; memory refuses the first request
      c_v = 1; c_seq = 11;
      step();
      chk("R4 two committed", wb_pending, 2);
      chk("R5 request raised", wb_will, 1);
      m_ready = 0;
      step();
      chk("R6 blocked after refusal", wb_will, 0);
      m_retry = 1;
      step();
      chk("R6 reissued after retry", wb_will, 1);
      chk("R3 addr of seq 10", wb_req_addr, 32'h1000 + 10 * 8);
      step();
      chk("R6 pending after accept", wb_pending, 1);
      chk("R3 addr of seq 11", wb_req_addr, 32'h1000 + 11 * 8);
      d_v = 1;
      step();
      chk("R7 occupancy after done", occupancy, 3);
      chk("R7 head moves to 11", head_seq, 11);

      // squash keeps 11, drops 12 and 13; same-cycle alloc ignored
      s_v = 1; s_seq = 11; a_v = 1; a_seq = 20;
      step();
      chk("R8 occupancy after squash", occupancy, 1);
      chk("R8 tail pulled back", alloc_idx, 2);

      // mixed traffic against the model
      nseq = 30;
      for (int i = 0; i < 300; i++) begin
         int fi, lastf;
         fi = -1; lastf = -1;
         for (int j = 0; j < q.size(); j++) begin
            if (q[j].size == 0 && fi < 0) fi = j;
            if (q[j].size != 0 && fi < 0) lastf = j;
         end
         if (i % 17 == 9) begin
            for (int j = 0; j < q.size(); j++)
               if (!q[j].com) begin s_v = 1; s_seq = 16'(q[j].seq); break; end
         end else begin
            if (i % 2 == 0) begin a_v = 1; a_seq = 16'(nseq); nseq++; end
            if (fi >= 0) fill_at(fi);
            if (i % 3 == 1 && lastf >= 0) begin c_v = 1; c_seq = 16'(q[lastf].seq); end
         end
         m_ready = (i % 5 != 3);
         m_retry = (i % 4 == 0);
         d_v     = (wbn > 0) && (i % 3 != 2);
         step();
      end

      // drain
      for (int i = 0; i < 40; i++) begin
         if (q.size() > 0) begin c_v = 1; c_seq = 16'hFFFF; end
         for (int j = 0; j < q.size(); j++)
            if (q[j].size == 0) begin fill_at(j); break; end
         m_retry = 1;
         d_v = (wbn > 0);
         step();
      end
      chk("R9 empty after drain", head_seq, 0);
      chk("R10 nothing pending", has_wb, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule